// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits in the read-data path of an electrically erasable memory model. It tells the host whether an internal programming cycle is still running. The write controller gives it two things for each byte lane: a busy flag and the byte most recently loaded into that lane. The block also receives the read strobes (chip enable, output enable and write enable, all active low) and the true data read from the array.

While a lane is busy, a read returns two status bits in that lane. Bit 7 is the inverse of bit 7 of the last byte written. Bit 6 flips with every new read access. The host can therefore poll either way, starting at any point in the write cycle. Bits 5..0 pass the array data and carry no meaning while the lane is busy. Once the busy flag drops, every bit of the lane carries true array data again.

A read access is counted on the system clock by a small tracker state machine. It has three states. ACC_OFF means no read is active. ACC_START is the single cycle in which a new access begins. ACC_HOLD means the access is still open. The transitions are:
- OFF_TO_START when the read condition is seen.
- START_TO_HOLD when the condition persists.
- START_TO_OFF or HOLD_TO_OFF when it goes away.

Top module: `prog_status_reporter`

## Requirements
- R1: After reset, dq_oe_o is 0 and dq_o is all zeros.
- R2: A read condition is ce_n=0, oe_n=0, we_n=1. The condition is sampled on the clock, and dq_oe_o is 1 exactly in the cycles after an edge that sampled it. While dq_oe_o is 0, dq_o is all zeros. With we_n=0 no read takes place.
- R3: In a lane whose busy flag is 0, a read returns the array byte of that lane unchanged.
- R4: In a lane whose busy flag is 1, bit 7 of that lane (bit 8*lane+7 of dq_o) reads as the inverse of bit 7 of the lane's last written byte.
- R5: In a busy lane, bit 6 (bit 8*lane+6) reads inverted on each new read access compared with the previous access, and holds one value for the whole of one access.
- R6: A new access may be opened by lowering oe_n while ce_n stays low, or by lowering ce_n while oe_n stays low. Both count for the bit 6 inversion.
- R7: A lane's toggle state is held while its busy flag is 0. Read accesses made while the lane is not busy do not change the bit 6 value seen at the next busy read.
- R8: Lanes are independent. A busy lane reports status while a non-busy lane in the same read returns true data.
- R9: When a lane's busy flag falls during an open access, that lane shows true array data in the same cycle, without waiting for a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy_i | input | LANES | Per-lane programming-in-progress flag |
| last_wr_i | input | 8*LANES | Last byte written, per lane |
| array_rd_i | input | 8*LANES | True array read data |
| dq_o | output | 8*LANES | Read data with status substitution |
| dq_oe_o | output | 1 | Read data valid / drive enable |

## Verification
Suppose the tracker state is wrong, for example stuck in ACC_START or failing to return to ACC_OFF. Bit 6 would then flip more than once inside one access, or dq_oe_o would stay high after the strobes rise. Both show up within one to two clocks of the access edge. A toggle register that moves while its lane is idle is invisible until the next busy read. At that read, bit 6 has the wrong polarity relative to the last busy value. A lane mixing up status and true data shows a wrong bit 7 or stale data in the first cycle the output is enabled.

// File: rtl/prog_status_pkg.sv
package prog_status_pkg;

    localparam int unsigned LANE_W   = 8;
    localparam int unsigned POLL_BIT = 7;
    localparam int unsigned FLIP_BIT = 6;

    typedef enum logic [1:0] {
        ACC_OFF   = 2'd0,
        ACC_START = 2'd1,
        ACC_HOLD  = 2'd2
    } acc_state_e;

endpackage

// File: rtl/read_access_fsm.sv
module read_access_fsm
    import prog_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    output acc_state_e state_o,
    output logic       access_start_o,
    output logic       access_on_o
);

    acc_state_e state_q;
    acc_state_e state_d;
    logic       rd_req;

    assign rd_req = !ce_n && !oe_n && we_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_OFF:   state_d = rd_req ? ACC_START : ACC_OFF;   // OFF_TO_START
            ACC_START: state_d = rd_req ? ACC_HOLD  : ACC_OFF;   // START_TO_HOLD / START_TO_OFF
            ACC_HOLD:  state_d = rd_req ? ACC_HOLD  : ACC_OFF;   // HOLD_TO_OFF
            default:   state_d = ACC_OFF;
        endcase
    end

    // outputs
    always_comb begin
        access_start_o = 1'b0;
        access_on_o    = 1'b0;
        unique case (state_q)
            ACC_OFF:   ;
            ACC_START: begin
                access_start_o = 1'b1;
                access_on_o    = 1'b1;
            end
            ACC_HOLD:  access_on_o = 1'b1;
            default:   ;
        endcase
    end

    assign state_o = state_q;

    // a start lasts exactly one cycle
    assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_START) |=> (state_q != ACC_START));

    // losing the read condition closes the access at the next edge
    assert_close_on_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (state_q == ACC_OFF));

endmodule

// File: rtl/lane_status_fmt.sv
module lane_status_fmt
    import prog_status_pkg::*;
#(
    parameter int unsigned BW = LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          access_start_i,
    input  logic          access_on_i,
    input  logic [BW-1:0] last_wr_i,
    input  logic [BW-1:0] array_i,
    output logic [BW-1:0] dq_o
);

    logic tog_q;
    logic tog_view;

    // toggle moves only on a new access while programming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (busy_i && access_start_i) begin
            tog_q <= ~tog_q;
        end
    end

    // the start cycle already shows the value the access will keep
    assign tog_view = access_start_i ? ~tog_q : tog_q;

    always_comb begin
        dq_o = '0;
        if (access_on_i) begin
            dq_o = array_i;
            if (busy_i) begin
                dq_o[POLL_BIT] = ~last_wr_i[POLL_BIT];
                dq_o[FLIP_BIT] = tog_view;
            end
        end
    end

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> $stable(tog_q));

    assert_flip_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && access_start_i) |=> (tog_q != $past(tog_q)));

endmodule

// File: rtl/prog_status_reporter.sv
module prog_status_reporter
    import prog_status_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce_n,
    input  logic                      oe_n,
    input  logic                      we_n,
    input  logic [LANES-1:0]          busy_i,
    input  logic [LANES*LANE_W-1:0]   last_wr_i,
    input  logic [LANES*LANE_W-1:0]   array_rd_i,
    output logic [LANES*LANE_W-1:0]   dq_o,
    output logic                      dq_oe_o
);

    localparam int unsigned DW = LANES * LANE_W;

    acc_state_e acc_state;
    logic       acc_start;
    logic       acc_on;
    logic [DW-1:0] lane_dq;

    read_access_fsm u_acc (
        .clk            (clk),
        .rst_n          (rst_n),
        .ce_n           (ce_n),
        .oe_n           (oe_n),
        .we_n           (we_n),
        .state_o        (acc_state),
        .access_start_o (acc_start),
        .access_on_o    (acc_on)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_status_fmt #(.BW(LANE_W)) u_fmt (
            .clk            (clk),
            .rst_n          (rst_n),
            .busy_i         (busy_i[g]),
            .access_start_i (acc_start),
            .access_on_i    (acc_on),
            .last_wr_i      (last_wr_i[g*LANE_W +: LANE_W]),
            .array_i        (array_rd_i[g*LANE_W +: LANE_W]),
            .dq_o           (lane_dq[g*LANE_W +: LANE_W])
        );

        assert_poll_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (dq_oe_o && busy_i[g]) |->
                (dq_o[g*LANE_W + POLL_BIT] == ~last_wr_i[g*LANE_W + POLL_BIT]));

        assert_true_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (dq_oe_o && !busy_i[g]) |->
                (dq_o[g*LANE_W +: LANE_W] == array_rd_i[g*LANE_W +: LANE_W]));
    end

    assign dq_o    = lane_dq;
    assign dq_oe_o = acc_on;

    assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe_o |-> (dq_o == '0));

    assert_open_only_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> (acc_state != ACC_OFF));

endmodule

// File: tb/prog_status_reporter_bench.sv
module prog_status_reporter_bench;

    localparam int LANES = 4;
    localparam int DW    = LANES * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ce_n = 1'b1;
    logic             oe_n = 1'b1;
    logic             we_n = 1'b1;
    logic [LANES-1:0] busy_i = '0;
    logic [DW-1:0]    last_wr_i = '0;
    logic [DW-1:0]    array_rd_i = '0;
    logic [DW-1:0]    dq_o;
    logic             dq_oe_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    prog_status_reporter #(.LANES(LANES)) u_prog_status_reporter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .busy_i     (busy_i),
        .last_wr_i  (last_wr_i),
        .array_rd_i (array_rd_i),
        .dq_o       (dq_o),
        .dq_oe_o    (dq_oe_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic open_read();
        @(negedge clk);
        ce_n = 1'b0;
        oe_n = 1'b0;
        @(negedge clk);
    endtask

    // via_ce=1 closes with chip enable, otherwise with output enable
    task automatic close_read(input bit via_ce);
        @(negedge clk);
        if (via_ce) ce_n = 1'b1;
        else        oe_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle_bus();
        @(negedge clk);
        ce_n = 1'b1;
        oe_n = 1'b1;
        we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 oe", {{(DW-1){1'b0}}, dq_oe_o}, '0);
        check("R1 dq", dq_o, '0);
    endtask

    task automatic t_idle_read();
        busy_i = '0;
        array_rd_i = 32'h1234_5678;
        open_read();
        check("R2 oe on", {{(DW-1){1'b0}}, dq_oe_o}, 1);
        check("R3 true data", dq_o, 32'h1234_5678);
        array_rd_i = 32'hC0DE_F00D;
        @(negedge clk);
        check("R3 follows array", dq_o, 32'hC0DE_F00D);
        close_read(1'b1);
        check("R2 oe off", {{(DW-1){1'b0}}, dq_oe_o}, 0);
        check("R2 quiet dq", dq_o, '0);
        idle_bus();
    endtask

    task automatic t_write_inhibit();
        @(negedge clk);
        we_n = 1'b0;
        ce_n = 1'b0;
        oe_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R2 we low no read", {{(DW-1){1'b0}}, dq_oe_o}, 0);
        check("R2 we low quiet", dq_o, '0);
        idle_bus();
    endtask

    task automatic t_poll_bit();
        array_rd_i = 32'h3355_77FF;
        busy_i = 4'b0001;
        last_wr_i = 32'h0000_00A5;
        open_read();
        check("R4 bit7 of A5", {{(DW-1){1'b0}}, dq_o[7]}, 0);
        check("R8 other lanes", {8'h00, dq_o[31:8]}, {8'h00, 24'h3355_77});
        close_read(1'b1);
        last_wr_i = 32'h0000_003C;
        open_read();
        check("R4 bit7 of 3C", {{(DW-1){1'b0}}, dq_o[7]}, 1);
        close_read(1'b1);
        busy_i = 4'b0100;
        last_wr_i = 32'h0080_0000;
        open_read();
        check("R8 lane2 bit7", {{(DW-1){1'b0}}, dq_o[23]}, 0);
        check("R8 lane0 true", {24'h0, dq_o[7:0]}, 32'hFF);
        close_read(1'b1);
        busy_i = '0;
        idle_bus();
    endtask

    task automatic t_toggle_oe();
        logic b0, b1, b2;
        busy_i = 4'b0001;
        last_wr_i = 32'h0000_0011;
        @(negedge clk);
        ce_n = 1'b0;
        open_read();
        b0 = dq_o[6];
        @(negedge clk);
        check("R5 stable in access", {{(DW-1){1'b0}}, dq_o[6]}, {{(DW-1){1'b0}}, b0});
        close_read(1'b0);
        open_read();
        b1 = dq_o[6];
        check("R5 flip oe 1", {{(DW-1){1'b0}}, b1}, {{(DW-1){1'b0}}, ~b0});
        close_read(1'b0);
        open_read();
        b2 = dq_o[6];
        check("R5 flip oe 2", {{(DW-1){1'b0}}, b2}, {{(DW-1){1'b0}}, ~b1});
        close_read(1'b0);
        idle_bus();
    endtask

    task automatic t_toggle_ce();
        logic b0, b1;
        busy_i = 4'b0001;
        @(negedge clk);
        oe_n = 1'b0;
        open_read();
        b0 = dq_o[6];
        close_read(1'b1);
        open_read();
        b1 = dq_o[6];
        check("R6 flip via ce", {{(DW-1){1'b0}}, b1}, {{(DW-1){1'b0}}, ~b0});
        close_read(1'b1);
        idle_bus();
    endtask

    task automatic t_hold_idle();
        logic b0, b1;
        busy_i = 4'b0001;
        open_read();
        b0 = dq_o[6];
        close_read(1'b1);
        busy_i = '0;
        array_rd_i = 32'h0000_0000;
        open_read();
        check("R7 idle read true", dq_o, 32'h0);
        close_read(1'b1);
        busy_i = 4'b0001;
        open_read();
        b1 = dq_o[6];
        check("R7 held while idle", {{(DW-1){1'b0}}, b1}, {{(DW-1){1'b0}}, ~b0});
        close_read(1'b1);
        busy_i = '0;
        idle_bus();
    endtask

    task automatic t_busy_fall();
        busy_i = 4'b0001;
        last_wr_i = 32'h0000_00FF;
        array_rd_i = 32'hAAAA_AAFF;
        open_read();
        check("R9 status before", {{(DW-1){1'b0}}, dq_o[7]}, 0);
        @(negedge clk);
        busy_i = '0;
        #1;
        check("R9 true at once", dq_o, 32'hAAAA_AAFF);
        close_read(1'b1);
        idle_bus();
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_read();
        t_write_inhibit();
        t_poll_bit();
        t_toggle_oe();
        t_toggle_ce();
        t_hold_idle();
        t_busy_fall();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule